// File: doc/BRIEF.md
# Quote-Aware Token Splitter

This block is a streaming transducer that cuts a byte stream of ASCII text into tokens. One character enters per cycle in which `in_valid` is high. Outside a double-quoted region a space separates tokens. Inside such a region a space is ordinary token content. The quote marks only switch the mode: they are swallowed and never reach the output, so a quoted region glues itself to any unquoted characters that touch it.

Each token leaves the block as a run of output beats, one character per beat. The first character of a token carries `out_first` and the final one carries `out_last`. A token is not known to be finished until a separator or the end of the stream arrives. For that reason the newest token character is held back in a register until its role is resolved.

A stream ends with a beat flagged by `in_last`. The cycle after that beat is a drain cycle. It closes any open token and reports a stream that ended inside an open quote.

Top module: `token_splitter`

## Requirements
- R1: Each cycle with `in_valid` high consumes exactly one character. Every token character is emitted exactly once, in input order, on registered outputs.
- R2: In plain mode, byte 0x20 ends an open token. Several spaces in a row, or leading and trailing spaces, produce no empty token.
- R3: Byte 0x22 toggles between plain and quoted mode and opens a token if none is open. It never appears on `out_char` while `out_valid` is high.
- R4: In quoted mode, every byte other than 0x22 is token content, 0x20 included.
- R5: Quoted and unquoted characters with no plain-mode space between them form a single token.
- R6: A token character is held until the next token character arrives, or until the token closes. In the first case it is emitted one cycle after that next character is consumed, with `out_last`=0. In the second case it is emitted with `out_last`=1. The beat appears in the cycle after the separator edge or the drain edge. `out_first`=1 marks only the first character of each token.
- R7: A token with no characters (for example a bare pair of quotes) is reported as a single beat with `out_valid`=0, `out_first`=1 and `out_last`=1.
- R8: A beat with `in_last` is processed like any other beat, and the following cycle is a drain cycle. The drain cycle closes any open token, returns the block to plain mode, and drops any beat offered during it.
- R9: If the drain cycle finds quoted mode, `err_unterminated` is 1 for exactly one cycle, on the same beat as the token's closing beat. In every other cycle it is 0.
- R10: Synchronous reset puts the block in plain mode with no token open and nothing held, and clears all outputs to 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous reset, active high |
| in_valid | input | 1 | A character is offered this cycle |
| in_char | input | CHAR_W | Offered character |
| in_last | input | 1 | Offered character is the final one of the stream |
| out_valid | output | 1 | `out_char` carries a token character |
| out_char | output | CHAR_W | Emitted token character |
| out_first | output | 1 | Beat opens a token |
| out_last | output | 1 | Beat closes a token |
| err_unterminated | output | 1 | Stream ended inside a quoted region |

## Verification
A mode bit stuck on the wrong side shows on the very next space. Either a token splits where it should not, or two tokens merge into one. The merged token reveals itself once the token's characters come out, or at the latest at the drain of that stream through a missing or extra `err_unterminated`. A stale held character or token-open flag surfaces after the next stream boundary as a character glued onto the following token or as a spurious empty-token beat. The bench therefore runs streams back to back, after a mid-stream reset and after a beat offered during the drain cycle. In each case it compares every output beat with tokens computed from the text itself.

// File: rtl/tsplit_pkg.sv
package tsplit_pkg;

   typedef enum logic [1:0] {
      CLS_TEXT  = 2'd0,
      CLS_SEP   = 2'd1,
      CLS_QUOTE = 2'd2
   } tsp_class_e;

   typedef enum logic {
      MODE_PLAIN  = 1'b0,
      MODE_QUOTED = 1'b1
   } tsp_mode_e;

   // actions the control stage hands to the hold stage, one cycle at a time
   typedef struct packed {
      logic push;    // a token character is consumed
      logic close;   // the open token ends now
      logic err;     // the ending token was left unterminated
   } tsp_act_s;

endpackage

// File: rtl/tsp_classify.sv
module tsp_classify
   import tsplit_pkg::*;
#(
   parameter int unsigned CHAR_W     = 8,
   parameter int unsigned SEP_CODE   = 32'h20,
   parameter int unsigned QUOTE_CODE = 32'h22
) (
   input  logic [CHAR_W-1:0] ch,
   input  tsp_mode_e         mode,
   output tsp_class_e        cls
);

   localparam logic [CHAR_W-1:0] SEP_C   = CHAR_W'(SEP_CODE);
   localparam logic [CHAR_W-1:0] QUOTE_C = CHAR_W'(QUOTE_CODE);

   always_comb begin
      if (ch == QUOTE_C) begin
         cls = CLS_QUOTE;
      end else if ((ch == SEP_C) && (mode == MODE_PLAIN)) begin
         cls = CLS_SEP;
      end else begin
         cls = CLS_TEXT;
      end
   end

endmodule

// File: rtl/tsp_ctrl.sv
module tsp_ctrl
   import tsplit_pkg::*;
(
   input  logic       clk,
   input  logic       rst,
   input  logic       in_valid,
   input  logic       in_last,
   input  tsp_class_e cls,
   output tsp_mode_e  mode,
   output tsp_act_s   act
);

   tsp_mode_e mode_q;
   logic      open_q;
   logic      drain_q;
   logic      beat;

   assign mode = mode_q;
   assign beat = in_valid && !drain_q;

   always_comb begin
      act.push  = beat && (cls == CLS_TEXT);
      act.close = open_q && ((beat && (cls == CLS_SEP)) || drain_q);
      act.err   = drain_q && open_q && (mode_q == MODE_QUOTED);
   end

   always_ff @(posedge clk) begin
      if (rst) begin
         mode_q  <= MODE_PLAIN;
         open_q  <= 1'b0;
         drain_q <= 1'b0;
      end else if (drain_q) begin
         mode_q  <= MODE_PLAIN;
         open_q  <= 1'b0;
         drain_q <= 1'b0;
      end else if (in_valid) begin
         unique case (cls)
            CLS_QUOTE: begin
               mode_q <= (mode_q == MODE_PLAIN) ? MODE_QUOTED : MODE_PLAIN;
               open_q <= 1'b1;
            end
            CLS_SEP:  open_q <= 1'b0;
            default:  open_q <= 1'b1;
         endcase
         drain_q <= in_last;
      end
   end

   // R3: a quote beat always flips the mode
   assert_quote_toggle_R3: assert property (@(posedge clk) disable iff (rst)
      (beat && (cls == CLS_QUOTE)) |=> (mode_q != $past(mode_q)));

   // R8: a drain cycle leaves the machine idle in plain mode
   assert_drain_home_R8: assert property (@(posedge clk) disable iff (rst)
      drain_q |=> (mode_q == MODE_PLAIN) && !open_q && !drain_q);

   // R10: the cycle after a reset edge starts from the idle state
   logic rst_q;
   always_ff @(posedge clk) rst_q <= rst;
   always @(posedge clk) begin
      if (rst_q === 1'b1) begin
         assert_reset_home_R10: assert ((mode_q == MODE_PLAIN) && !open_q && !drain_q);
      end
   end

endmodule

// File: rtl/tsp_hold.sv
module tsp_hold
   import tsplit_pkg::*;
#(
   parameter int unsigned CHAR_W = 8
) (
   input  logic              clk,
   input  logic              rst,
   input  tsp_act_s          act,
   input  logic [CHAR_W-1:0] ch,
   output logic              o_valid,
   output logic [CHAR_W-1:0] o_char,
   output logic              o_first,
   output logic              o_last,
   output logic              o_err
);

   logic              have_q;
   logic [CHAR_W-1:0] pend_q;
   logic              pfirst_q;

   always_ff @(posedge clk) begin
      if (rst) begin
         have_q   <= 1'b0;
         pend_q   <= '0;
         pfirst_q <= 1'b0;
         o_valid  <= 1'b0;
         o_char   <= '0;
         o_first  <= 1'b0;
         o_last   <= 1'b0;
         o_err    <= 1'b0;
      end else begin
         o_valid <= 1'b0;
         o_first <= 1'b0;
         o_last  <= 1'b0;
         o_err   <= act.err;
         if (act.push) begin
            if (have_q) begin
               o_valid <= 1'b1;
               o_char  <= pend_q;
               o_first <= pfirst_q;
            end
            pend_q   <= ch;
            pfirst_q <= !have_q;
            have_q   <= 1'b1;
         end else if (act.close) begin
            if (have_q) begin
               o_valid <= 1'b1;
               o_char  <= pend_q;
               o_first <= pfirst_q;
            end else begin
               o_first <= 1'b1;
            end
            o_last   <= 1'b1;
            have_q   <= 1'b0;
            pfirst_q <= 1'b0;
         end
      end
   end

   // R6: a non-final character leaves a successor held behind it
   assert_holdback_R6: assert property (@(posedge clk) disable iff (rst)
      (o_valid && !o_last) |-> have_q);

   // R7: a close marker without a character is always a whole empty token
   assert_empty_mark_R7: assert property (@(posedge clk) disable iff (rst)
      (o_last && !o_valid) |-> o_first);

endmodule

// File: rtl/token_splitter.sv
module token_splitter
   import tsplit_pkg::*;
#(
   parameter int unsigned CHAR_W     = 8,
   parameter int unsigned SEP_CODE   = 32'h20,
   parameter int unsigned QUOTE_CODE = 32'h22
) (
   input  logic              clk,
   input  logic              rst,
   input  logic              in_valid,
   input  logic [CHAR_W-1:0] in_char,
   input  logic              in_last,
   output logic              out_valid,
   output logic [CHAR_W-1:0] out_char,
   output logic              out_first,
   output logic              out_last,
   output logic              err_unterminated
);

   localparam logic [CHAR_W-1:0] QUOTE_C = CHAR_W'(QUOTE_CODE);

   generate
      if (CHAR_W < 2 || CHAR_W > 32) begin : g_bad_width
         $error("token_splitter: CHAR_W out of range");
      end
      if (SEP_CODE == QUOTE_CODE) begin : g_bad_codes
         $error("token_splitter: separator and quote codes must differ");
      end
      if (CHAR_W < 32) begin : g_code_fit
         if ((SEP_CODE >> CHAR_W) != 0 || (QUOTE_CODE >> CHAR_W) != 0) begin : g_bad_fit
            $error("token_splitter: a code does not fit in CHAR_W");
         end
      end
   endgenerate

   tsp_class_e cls;
   tsp_mode_e  mode;
   tsp_act_s   act;

   tsp_classify #(
      .CHAR_W     (CHAR_W),
      .SEP_CODE   (SEP_CODE),
      .QUOTE_CODE (QUOTE_CODE)
   ) classify_i (
      .ch   (in_char),
      .mode (mode),
      .cls  (cls)
   );

   tsp_ctrl ctrl_i (
      .clk      (clk),
      .rst      (rst),
      .in_valid (in_valid),
      .in_last  (in_last),
      .cls      (cls),
      .mode     (mode),
      .act      (act)
   );

   tsp_hold #(
      .CHAR_W (CHAR_W)
   ) hold_i (
      .clk     (clk),
      .rst     (rst),
      .act     (act),
      .ch      (in_char),
      .o_valid (out_valid),
      .o_char  (out_char),
      .o_first (out_first),
      .o_last  (out_last),
      .o_err   (err_unterminated)
   );

   // R3: quote bytes are consumed, never emitted
   assert_no_quote_out_R3: assert property (@(posedge clk) disable iff (rst)
      out_valid |-> (out_char != QUOTE_C));

   // R9: the error flag rides on a token's closing beat
   assert_err_on_close_R9: assert property (@(posedge clk) disable iff (rst)
      err_unterminated |-> out_last);

endmodule

// File: tb/token_splitter_tb_top.sv
`timescale 1ns/1ps
module token_splitter_tb_top;

   logic       clk = 1'b0;
   logic       rst = 1'b1;
   logic       in_valid = 1'b0;
   logic [7:0] in_char = 8'h00;
   logic       in_last = 1'b0;
   logic       out_valid, out_first, out_last, err_unterminated;
   logic [7:0] out_char;

   always #2.5 clk = ~clk;

   token_splitter dut_i (
      .clk              (clk),
      .rst              (rst),
      .in_valid         (in_valid),
      .in_char          (in_char),
      .in_last          (in_last),
      .out_valid        (out_valid),
      .out_char         (out_char),
      .out_first        (out_first),
      .out_last         (out_last),
      .err_unterminated (err_unterminated)
   );

   typedef struct {
      logic       v;
      logic [7:0] c;
      logic       f;
      logic       l;
      logic       e;
      string      tag;
   } exp_t;

   exp_t expq[$];
   int   n_chk = 0;
   int   n_bad = 0;
   bit   finished = 0;

   task automatic check(string tag, string what, logic [7:0] act, logic [7:0] expv);
      n_chk++;
      if (act !== expv) begin
         n_bad++;
         $display("FAIL %s %s: got %h expected %h", tag, what, act, expv);
      end
   endtask

   task automatic push_beat(logic v, logic [7:0] c, logic f, logic l, logic e, string tag);
      exp_t x;
      x.v = v; x.c = c; x.f = f; x.l = l; x.e = e; x.tag = tag;
      expq.push_back(x);
   endtask

   task automatic push_token(byte t[$], logic err, string tag);
      if (t.size() == 0) begin
         push_beat(1'b0, 8'h00, 1'b1, 1'b1, err, tag);
      end else begin
         for (int j = 0; j < t.size(); j++) begin
            push_beat(1'b1, t[j], j == 0, j == t.size() - 1,
                      err && (j == t.size() - 1), tag);
         end
      end
   endtask

   // text-level tokenizer built from the requirements
   task automatic expect_stream(string s, string tag);
      byte tok[$];
      bit  open = 0;
      bit  q = 0;
      for (int i = 0; i < s.len(); i++) begin
         byte c;
         c = s[i];
         if (c == 8'h22) begin
            q = !q;
            open = 1;
         end else if (c == 8'h20 && !q) begin
            if (open) push_token(tok, 1'b0, tag);
            open = 0;
            tok.delete();
         end else begin
            tok.push_back(c);
            open = 1;
         end
      end
      if (open) push_token(tok, q, tag);
   endtask

   task automatic drive_stream(string s, string tag);
      expect_stream(s, tag);
      for (int i = 0; i < s.len(); i++) begin
         @(negedge clk);
         in_valid = 1'b1;
         in_char  = s[i];
         in_last  = (i == s.len() - 1);
      end
      @(negedge clk);
      in_valid = 1'b0;
      in_last  = 1'b0;
      repeat (2) @(negedge clk);
   endtask

   // scoreboard monitor
   always @(negedge clk) begin
      if (!rst && !finished && (out_valid || out_first || out_last || err_unterminated)) begin
         exp_t x;
         n_chk++;
         if (expq.size() == 0) begin
            n_bad++;
            $display("FAIL R1 unexpected beat: got v%b c%h f%b l%b e%b expected none",
                     out_valid, out_char, out_first, out_last, err_unterminated);
         end else begin
            x = expq.pop_front();
            if ({out_valid, out_first, out_last, err_unterminated} !== {x.v, x.f, x.l, x.e}
                || (x.v && out_char !== x.c)) begin
               n_bad++;
               $display("FAIL %s: got v%b c%h f%b l%b e%b expected v%b c%h f%b l%b e%b",
                        x.tag, out_valid, out_char, out_first, out_last, err_unterminated,
                        x.v, x.c, x.f, x.l, x.e);
            end
         end
      end
   end

   task automatic summary();
      finished = 1;
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
   endtask

   initial begin
      repeat (100000) @(posedge clk);
      if (!finished) begin
         n_chk++;
         n_bad++;
         $display("FAIL watchdog: got timeout expected completion");
         summary();
      end
   end

   initial begin
      // R10: outputs idle under reset
      repeat (3) @(negedge clk);
      check("R10", "out_valid", {7'd0, out_valid}, 8'd0);
      check("R10", "markers", {5'd0, out_first, out_last, err_unterminated}, 8'd0);
      rst = 1'b0;
      @(negedge clk);

      // R6: exact timing of the held character
      expect_stream("ab ", "R6");
      in_valid = 1'b1; in_char = "a"; in_last = 1'b0;
      @(negedge clk);
      in_char = "b";
      check("R6", "nothing after first char", {7'd0, out_valid}, 8'd0);
      @(negedge clk);
      in_char = " "; in_last = 1'b1;
      check("R6", "a emitted valid", {7'd0, out_valid}, 8'd1);
      check("R6", "a char", out_char, "a");
      check("R6", "a first/last", {6'd0, out_first, out_last}, 8'd2);
      @(negedge clk);
      in_valid = 1'b0; in_last = 1'b0;
      check("R6", "b char", out_char, "b");
      check("R6", "b first/last", {6'd0, out_first, out_last}, 8'd1);
      @(negedge clk);
      check("R8", "drain after closed token silent", {7'd0, out_valid}, 8'd0);
      repeat (2) @(negedge clk);

      drive_stream("hello world", "R1");
      drive_stream("  a   b  ", "R2");
      drive_stream("x \"p q\" y", "R4");
      drive_stream("ab\"c d\"ef", "R5");
      drive_stream("a \"\" b", "R7");
      drive_stream("\"\"", "R7");
      drive_stream("say \"oops", "R9");
      drive_stream("\"", "R9");
      drive_stream("\"a\"", "R3");

      // R8: beat offered in the drain cycle is dropped
      expect_stream("x", "R8");
      @(negedge clk);
      in_valid = 1'b1; in_char = "x"; in_last = 1'b1;
      @(negedge clk);
      in_char = "y"; in_last = 1'b0;
      @(negedge clk);
      in_valid = 1'b0;
      repeat (2) @(negedge clk);
      drive_stream("z", "R8");

      // R10: reset mid-token inside a quote
      push_beat(1'b1, "a", 1'b1, 1'b0, 1'b0, "R10");
      @(negedge clk);
      in_valid = 1'b1; in_char = 8'h22;
      @(negedge clk);
      in_char = "a";
      @(negedge clk);
      in_char = "b";
      @(negedge clk);
      in_valid = 1'b0;
      @(negedge clk);
      rst = 1'b1;
      repeat (2) @(negedge clk);
      check("R10", "cleared out_valid", {7'd0, out_valid}, 8'd0);
      rst = 1'b0;
      @(negedge clk);
      drive_stream("d e", "R10");

      repeat (5) @(negedge clk);
      check("R1", "pending expected beats", expq.size(), 8'd0);
      summary();
   end

endmodule